// File: doc/BRIEF.md
# Two-Dimensional Block Copy Address Sequencer

This block is the control half of a rectangle copy engine. Software loads a source and a destination word address, a pair of signed byte steps for each of them, a word count per line, a line count, three write masks, an op code and two per-line read-shaping flags. It then sets the busy bit. The sequencer walks the rectangle one destination word at a time. For each word it issues source reads, then a destination read only when the final value depends on the old destination, then the destination write. Every access waits on a request/acknowledge handshake before the next one.

The data path beside it (shifter, halftone store, logic unit) is driven by strobes. One pulses when source data arrives, one when a buffer half-shift happens without a read, and one when destination data arrives. The block also drives the mask for the current write and the 4-bit halftone row index. The working address, count and row registers are the live state, so software sees progress when it reads them back. A count of zero stands for 65536.

Top module: `blit_seq`

## Requirements
- R1: After reset, irq and mem_req are low and all eight configuration words (cfg_sel 0..7) read as zero.
- R2: Writing cfg_sel 7 with bit 31 set while idle starts a transfer. From the next cycle until the last write of the last line is acknowledged, bit 31 of word 7 and irq read 1. Nothing is requested while idle.
- R3: A transfer makes X·Y destination writes, where X is word 4 bits [15:0] and Y is bits [31:16]. Afterwards word 4 reads back X in the low half and 0 in the high half.
- R4: Destination addresses are word addresses (word 1). The steps are 15-bit byte offsets: X step in word 3 bits [14:0], Y step in bits [30:16]. Bit 0 of each step is ignored and the rest is sign-extended. The X step follows every write except the last of a line, and the Y step follows that last write.
- R5: The source uses word 0 for its address and word 2 for its steps, laid out as in R4. Each source read adds the X step, except the final source read of the line, which adds the Y step. Without R8 or R9, each destination word takes exactly one source read.
- R6: The first write of a line uses mask 1 (word 5 [15:0]), the last uses mask 3 (word 6 [15:0]) and the rest use mask 2 (word 5 [31:16]). A one-word line uses mask 1.
- R7: The op code is word 7 [3:0]. Its bits hold the result for (s,d) = (0,0),(0,1),(1,0),(1,1) from bit 3 down to bit 0. A destination read comes before a write only if the op depends on d or the mask is not all ones.
- R8: With word 7 bit 8 set, the first word of every line gets one extra source read.
- R9: With word 7 bit 9 set, the last word of every line has no source read. dp_src_shift pulses once in its place, and that word's write is always preceded by a destination read. With both flags set, a one-word line makes one source read.
- R10: At each line end, the row index (word 7 [7:4], dp_line) counts up modulo 16 if the destination Y step is non-negative and down if it is negative.
- R11: For each word the accesses come in the order source reads, destination read, write. A request holds its address and direction until it is acknowledged.
- R12: Configuration writes, including a ctrl write with bit 31 clear, are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Live read-back of the selected word |
| mem_req | output | 1 | Memory access request |
| mem_wr | output | 1 | Request is a write |
| mem_addr | output | 23 | Word address of the request |
| mem_ack | input | 1 | Memory accepts the current request |
| dp_src_load | output | 1 | Source word accepted, shift it into the buffer |
| dp_src_shift | output | 1 | Buffer half-shift without a read |
| dp_dst_load | output | 1 | Destination word accepted |
| dp_wr_mask | output | 16 | Mask of the current destination word |
| dp_line | output | 4 | Halftone row index |
| irq | output | 1 | Mirrors the busy bit |

## Verification
The properties assume that mem_ack is only raised while mem_req is high, and that the line count is non-zero so a transfer ends. The bench's memory model grants only a pending request, with a random wait of zero to two cycles. It programs widths of one to four words and one to three lines. Random ops, masks, steps and flag combinations are mixed with directed cases: constant ops with full masks, a one-word line with both flags, row-index wrap in both directions, and writes made while busy.

// File: rtl/blit_seq_pkg.sv
package blit_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_WORD = 3'd1,
        S_SRC  = 3'd2,
        S_DRD  = 3'd3,
        S_DWR  = 3'd4
    } seq_state_e;

    localparam logic [2:0] SEL_SRC_ADDR = 3'd0;
    localparam logic [2:0] SEL_DST_ADDR = 3'd1;
    localparam logic [2:0] SEL_SRC_STEP = 3'd2;
    localparam logic [2:0] SEL_DST_STEP = 3'd3;
    localparam logic [2:0] SEL_COUNTS   = 3'd4;
    localparam logic [2:0] SEL_MASK_LM  = 3'd5;
    localparam logic [2:0] SEL_MASK_R   = 3'd6;
    localparam logic [2:0] SEL_CTRL     = 3'd7;

    // true when the combination rule gives different results for d=0 and d=1
    function automatic logic op_reads_dst(input logic [3:0] op);
        return (op[3] ^ op[2]) | (op[1] ^ op[0]);
    endfunction

endpackage

// File: rtl/blit_addr_step.sv
module blit_addr_step #(
    parameter int AW = 23,
    parameter int IW = 15
) (
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] byte_inc,
    output logic [AW-1:0] next
);
    localparam int OW = IW - 1;

    logic [AW-1:0] word_ofs;
    logic          unused_lsb;

    assign unused_lsb = byte_inc[0];
    assign word_ofs   = {{(AW-OW){byte_inc[IW-1]}}, byte_inc[IW-1:1]};
    assign next       = base + word_ofs;
endmodule

// File: rtl/blit_src_plan.sv
module blit_src_plan #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] words_left,
    input  logic          first,
    input  logic          fxsr,
    input  logic          nfsr,
    output logic          last,
    output logic          hosts_final,
    output logic [1:0]    reads
);
    localparam logic [CW-1:0] ONE_W = CW'(1);
    localparam logic [CW-1:0] TWO_W = CW'(2);

    logic extra;
    logic skip;

    assign last        = (words_left == ONE_W);
    assign extra       = first & fxsr;
    assign skip        = last & nfsr;
    assign reads       = 2'd1 + {1'b0, extra} - {1'b0, skip};
    // the line's final source read sits in the last word, or one earlier when it is skipped
    assign hosts_final = last | (nfsr & (words_left == TWO_W));
endmodule

// File: rtl/blit_mask_pick.sv
module blit_mask_pick
    import blit_seq_pkg::*;
#(
    parameter int MW = 16
) (
    input  logic          first,
    input  logic          last,
    input  logic [MW-1:0] m_left,
    input  logic [MW-1:0] m_mid,
    input  logic [MW-1:0] m_right,
    input  logic [3:0]    op,
    input  logic          force_rmw,
    output logic [MW-1:0] mask,
    output logic          need_rd
);
    always_comb begin
        if (first)      mask = m_left;
        else if (last)  mask = m_right;
        else            mask = m_mid;
        need_rd = op_reads_dst(op) || (mask != {MW{1'b1}}) || force_rmw;
    end
endmodule

// File: rtl/blit_seq.sv
module blit_seq
    import blit_seq_pkg::*;
#(
    parameter int AW = 23,
    parameter int IW = 15,
    parameter int CW = 16,
    parameter int MW = 16,
    parameter int LW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    output logic          mem_req,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    output logic          dp_src_load,
    output logic          dp_src_shift,
    output logic          dp_dst_load,
    output logic [MW-1:0] dp_wr_mask,
    output logic [LW-1:0] dp_line,
    output logic          irq
);
    localparam int HALF = DW / 2;
    localparam logic [CW-1:0] ONE_C = CW'(1);
    localparam logic [LW-1:0] ONE_L = LW'(1);

    typedef struct packed {
        seq_state_e    st;
        logic          busy;
        logic          first;
        logic [1:0]    rd_left;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [IW-1:0] sxi;
        logic [IW-1:0] syi;
        logic [IW-1:0] dxi;
        logic [IW-1:0] dyi;
        logic [CW-1:0] xinit;
        logic [CW-1:0] xcnt;
        logic [CW-1:0] ycnt;
        logic [MW-1:0] m1;
        logic [MW-1:0] m2;
        logic [MW-1:0] m3;
        logic [3:0]    op;
        logic [LW-1:0] line;
        logic          fxsr;
        logic          nfsr;
    } seq_regs_t;

    seq_regs_t q, n;

    logic          last;
    logic          hosts_final;
    logic [1:0]    plan_reads;
    logic          src_final;
    logic          need_rd;
    logic [MW-1:0] cur_mask;
    logic          unused_wdata;

    logic [AW-1:0] step_base [2];
    logic [IW-1:0] step_inc  [2];
    logic [AW-1:0] step_next [2];

    assign unused_wdata = ^cfg_wdata;

    blit_src_plan #(.CW(CW)) u_plan (
        .words_left  (q.xcnt),
        .first       (q.first),
        .fxsr        (q.fxsr),
        .nfsr        (q.nfsr),
        .last        (last),
        .hosts_final (hosts_final),
        .reads       (plan_reads)
    );

    blit_mask_pick #(.MW(MW)) u_mask (
        .first     (q.first),
        .last      (last),
        .m_left    (q.m1),
        .m_mid     (q.m2),
        .m_right   (q.m3),
        .op        (q.op),
        .force_rmw (last & q.nfsr),
        .mask      (cur_mask),
        .need_rd   (need_rd)
    );

    assign src_final    = (q.rd_left == 2'd1) && hosts_final;
    assign step_base[0] = q.src;
    assign step_inc[0]  = src_final ? q.syi : q.sxi;
    assign step_base[1] = q.dst;
    assign step_inc[1]  = last ? q.dyi : q.dxi;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_step
            blit_addr_step #(.AW(AW), .IW(IW)) u_step (
                .base     (step_base[g]),
                .byte_inc (step_inc[g]),
                .next     (step_next[g])
            );
        end
    endgenerate

    // next-state logic
    always_comb begin
        n            = q;
        mem_req      = 1'b0;
        mem_wr       = 1'b0;
        mem_addr     = q.dst;
        dp_src_load  = 1'b0;
        dp_src_shift = 1'b0;
        dp_dst_load  = 1'b0;

        if (cfg_we && !q.busy) begin
            case (cfg_sel)
                SEL_SRC_ADDR: n.src = cfg_wdata[AW-1:0];
                SEL_DST_ADDR: n.dst = cfg_wdata[AW-1:0];
                SEL_SRC_STEP: begin
                    n.sxi = cfg_wdata[IW-1:0];
                    n.syi = cfg_wdata[HALF +: IW];
                end
                SEL_DST_STEP: begin
                    n.dxi = cfg_wdata[IW-1:0];
                    n.dyi = cfg_wdata[HALF +: IW];
                end
                SEL_COUNTS: begin
                    n.xinit = cfg_wdata[CW-1:0];
                    n.xcnt  = cfg_wdata[CW-1:0];
                    n.ycnt  = cfg_wdata[HALF +: CW];
                end
                SEL_MASK_LM: begin
                    n.m1 = cfg_wdata[MW-1:0];
                    n.m2 = cfg_wdata[HALF +: MW];
                end
                SEL_MASK_R: n.m3 = cfg_wdata[MW-1:0];
                default: begin
                    n.op   = cfg_wdata[3:0];
                    n.line = cfg_wdata[4 +: LW];
                    n.fxsr = cfg_wdata[8];
                    n.nfsr = cfg_wdata[9];
                    if (cfg_wdata[DW-1]) begin
                        n.busy  = 1'b1;
                        n.first = 1'b1;
                        n.xcnt  = q.xinit;
                        n.st    = S_WORD;
                    end
                end
            endcase
        end

        case (q.st)
            S_IDLE: ;
            S_WORD: begin
                if (plan_reads == 2'd0) begin
                    dp_src_shift = 1'b1;
                    n.st         = need_rd ? S_DRD : S_DWR;
                end else begin
                    n.rd_left = plan_reads;
                    n.st      = S_SRC;
                end
            end
            S_SRC: begin
                mem_req  = 1'b1;
                mem_addr = q.src;
                if (mem_ack) begin
                    dp_src_load = 1'b1;
                    n.src       = step_next[0];
                    n.rd_left   = q.rd_left - 2'd1;
                    if (q.rd_left == 2'd1) n.st = need_rd ? S_DRD : S_DWR;
                end
            end
            S_DRD: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    dp_dst_load = 1'b1;
                    n.st        = S_DWR;
                end
            end
            S_DWR: begin
                mem_req = 1'b1;
                mem_wr  = 1'b1;
                if (mem_ack) begin
                    n.dst = step_next[1];
                    if (last) begin
                        n.xcnt  = q.xinit;
                        n.first = 1'b1;
                        n.ycnt  = q.ycnt - ONE_C;
                        n.line  = q.dyi[IW-1] ? q.line - ONE_L : q.line + ONE_L;
                        if (q.ycnt == ONE_C) begin
                            n.busy = 1'b0;
                            n.st   = S_IDLE;
                        end else begin
                            n.st = S_WORD;
                        end
                    end else begin
                        n.xcnt  = q.xcnt - ONE_C;
                        n.first = 1'b0;
                        n.st    = S_WORD;
                    end
                end
            end
            default: n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    // live read-back
    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            SEL_SRC_ADDR: cfg_rdata[AW-1:0] = q.src;
            SEL_DST_ADDR: cfg_rdata[AW-1:0] = q.dst;
            SEL_SRC_STEP: begin
                cfg_rdata[IW-1:0]    = q.sxi;
                cfg_rdata[HALF +: IW] = q.syi;
            end
            SEL_DST_STEP: begin
                cfg_rdata[IW-1:0]    = q.dxi;
                cfg_rdata[HALF +: IW] = q.dyi;
            end
            SEL_COUNTS: begin
                cfg_rdata[CW-1:0]    = q.xcnt;
                cfg_rdata[HALF +: CW] = q.ycnt;
            end
            SEL_MASK_LM: begin
                cfg_rdata[MW-1:0]    = q.m1;
                cfg_rdata[HALF +: MW] = q.m2;
            end
            SEL_MASK_R: cfg_rdata[MW-1:0] = q.m3;
            default: begin
                cfg_rdata[3:0]     = q.op;
                cfg_rdata[4 +: LW] = q.line;
                cfg_rdata[8]       = q.fxsr;
                cfg_rdata[9]       = q.nfsr;
                cfg_rdata[DW-1]    = q.busy;
            end
        endcase
    end

    assign dp_wr_mask = cur_mask;
    assign dp_line    = q.line;
    assign irq        = q.busy;
endmodule

// File: rtl/blit_seq_chk.sv
module blit_seq_chk #(
    parameter int AW = 23,
    parameter int LW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          dp_src_load,
    input logic          dp_src_shift,
    input logic [LW-1:0] dp_line,
    input logic          irq
);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wr)));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> !mem_req);

    assert_done_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(mem_req && mem_wr && mem_ack));

    assert_src_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dp_src_load |-> (mem_req && !mem_wr && mem_ack));

    assert_shift_no_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dp_src_shift |-> !mem_req);

    assert_row_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((dp_line != $past(dp_line)) && $past(irq)) |-> $past(mem_req && mem_wr && mem_ack));
endmodule

bind blit_seq blit_seq_chk #(.AW(AW), .LW(LW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req      (mem_req),
    .mem_wr       (mem_wr),
    .mem_addr     (mem_addr),
    .mem_ack      (mem_ack),
    .dp_src_load  (dp_src_load),
    .dp_src_shift (dp_src_shift),
    .dp_line      (dp_line),
    .irq          (irq)
);

// File: tb/blit_seq_test.sv
module blit_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_req, mem_wr, mem_ack = 1'b0;
    logic [22:0] mem_addr;
    logic        dp_src_load, dp_src_shift, dp_dst_load;
    logic [15:0] dp_wr_mask;
    logic [3:0]  dp_line;
    logic        irq;

    blit_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .dp_src_load(dp_src_load), .dp_src_shift(dp_src_shift),
        .dp_dst_load(dp_dst_load), .dp_wr_mask(dp_wr_mask),
        .dp_line(dp_line), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int errs  = 0;
    bit done  = 0;

    // observed trace: kind 0 source read, 1 destination read, 2 write
    logic [1:0]  tk [256];
    logic [22:0] ta [256];
    logic [15:0] tm [256];
    int tn = 0;
    int shifts = 0;
    // expected trace
    logic [1:0]  ek [256];
    logic [22:0] ea [256];
    logic [15:0] em [256];
    int en = 0;
    int eshift = 0;
    logic [22:0] e_src, e_dst;
    logic [3:0]  e_line;

    // configuration under test
    logic [22:0] c_src, c_dst;
    logic [14:0] c_sxi, c_syi, c_dxi, c_dyi;
    int          c_x, c_y;
    logic [15:0] c_m1, c_m2, c_m3;
    logic [3:0]  c_op, c_line;
    bit          c_fx, c_nf;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [22:0] step_w(input logic [22:0] a, input logic [14:0] inc);
        return a + {{9{inc[14]}}, inc[14:1]};
    endfunction

    function automatic bit uses_d(input logic [3:0] op);
        // result differs between d=0 and d=1 for some s
        return (op[3] != op[2]) || (op[1] != op[0]);
    endfunction

    task automatic push(input logic [1:0] k, input logic [22:0] a, input logic [15:0] m);
        ek[en] = k; ea[en] = a; em[en] = m; en++;
    endtask

    task automatic build_model();
        logic [22:0] sa, da;
        logic [3:0]  ln;
        sa = c_src; da = c_dst; ln = c_line; en = 0; eshift = 0;
        for (int l = 0; l < c_y; l++) begin
            for (int w = 0; w < c_x; w++) begin
                bit first, last, need, fin;
                int reads, cnt;
                logic [15:0] mask;
                first = (w == 0);
                last  = (w == c_x - 1);
                cnt   = c_x - w;
                reads = 1 + ((first && c_fx) ? 1 : 0) - ((last && c_nf) ? 1 : 0);
                if (reads == 0) eshift++;
                for (int r = 0; r < reads; r++) begin
                    fin = (r == reads - 1) && (last || (c_nf && cnt == 2));
                    push(2'd0, sa, 16'h0);
                    sa = step_w(sa, fin ? c_syi : c_sxi);
                end
                mask = first ? c_m1 : (last ? c_m3 : c_m2);
                need = uses_d(c_op) || (mask != 16'hFFFF) || (last && c_nf);
                if (need) push(2'd1, da, 16'h0);
                push(2'd2, da, mask);
                da = step_w(da, last ? c_dyi : c_dxi);
            end
            ln = c_dyi[14] ? ln - 4'd1 : ln + 4'd1;
        end
        e_src = sa; e_dst = da; e_line = ln;
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] sel, output logic [31:0] data);
        @(negedge clk);
        cfg_sel = sel;
        #1 data = cfg_rdata;
    endtask

    // memory model: grants a pending request after 0..2 cycles
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            #1;
            if (dp_src_shift) shifts++;
            if (mem_req) begin
                if (dly == 0) begin
                    mem_ack = 1'b1;
                    #1;
                    if (tn < 256) begin
                        tk[tn] = mem_wr ? 2'd2 : (dp_src_load ? 2'd0 : 2'd1);
                        ta[tn] = mem_addr;
                        tm[tn] = mem_wr ? dp_wr_mask : 16'h0;
                        tn++;
                    end
                    dly = $urandom % 3;
                end else begin
                    dly--;
                end
            end
        end
    end

    task automatic run_one(input string name, input bit poke);
        logic [31:0] rd;
        int lim;
        cfg_write(3'd0, {9'd0, c_src});
        cfg_write(3'd1, {9'd0, c_dst});
        cfg_write(3'd2, {1'b0, c_syi, 1'b0, c_sxi});
        cfg_write(3'd3, {1'b0, c_dyi, 1'b0, c_dxi});
        cfg_write(3'd4, {16'(c_y), 16'(c_x)});
        cfg_write(3'd5, {c_m2, c_m1});
        cfg_write(3'd6, {16'h0, c_m3});
        build_model();
        tn = 0; shifts = 0;
        cfg_write(3'd7, {1'b1, 21'd0, c_nf, c_fx, c_line, c_op});
        check({"R2 irq after start ", name}, 64'(irq), 64'd1);
        cfg_read(3'd7, rd);
        check({"R2 busy bit after start ", name}, 64'(rd[31]), 64'd1);
        if (poke) begin
            cfg_write(3'd1, 32'h0000_1234);
            cfg_write(3'd4, 32'h0009_0009);
            cfg_write(3'd5, 32'h0);
            cfg_write(3'd7, 32'h0000_00F3);
            check({"R12 still busy after ignored ctrl write ", name}, 64'(irq), 64'd1);
        end
        while (irq) @(negedge clk);
        repeat (2) @(negedge clk);
        check({"R3 R11 access count ", name}, 64'(tn), 64'(en));
        lim = (tn < en) ? tn : en;
        for (int i = 0; i < lim; i++) begin
            string tag;
            case (ek[i])
                2'd0:    tag = "R5 R8 source read";
                2'd1:    tag = "R7 R9 R11 destination read";
                default: tag = "R4 R6 R12 write";
            endcase
            check({tag, " ", name}, {tk[i], ta[i], tm[i]}, {ek[i], ea[i], em[i]});
        end
        check({"R9 shift pulses ", name}, 64'(shifts), 64'(eshift));
        cfg_read(3'd0, rd);
        check({"R5 final source address ", name}, 64'(rd), 64'({9'd0, e_src}));
        cfg_read(3'd1, rd);
        check({"R4 R12 final destination address ", name}, 64'(rd), 64'({9'd0, e_dst}));
        cfg_read(3'd4, rd);
        check({"R3 counts after done ", name}, 64'(rd), 64'({16'd0, 16'(c_x)}));
        cfg_read(3'd7, rd);
        check({"R10 R2 row and busy after done ", name}, 64'({rd[31], rd[7:4]}), 64'({1'b0, e_line}));
    endtask

    task automatic randomize_cfg();
        c_src  = 23'($urandom);
        c_dst  = 23'($urandom);
        c_sxi  = 15'($urandom);
        c_syi  = 15'($urandom);
        c_dxi  = 15'($urandom);
        c_dyi  = 15'($urandom);
        c_x    = 1 + ($urandom % 4);
        c_y    = 1 + ($urandom % 3);
        c_m1   = ($urandom % 2) ? 16'hFFFF : 16'($urandom);
        c_m2   = ($urandom % 2) ? 16'hFFFF : 16'($urandom);
        c_m3   = ($urandom % 2) ? 16'hFFFF : 16'($urandom);
        c_op   = 4'($urandom);
        c_line = 4'($urandom);
        c_fx   = 1'($urandom);
        c_nf   = 1'($urandom);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, errs);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            total++;
            $display("FAIL R2 watchdog: irq actual=%0b expected=0", irq);
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 irq in reset", 64'(irq), 64'd0);
        check("R1 mem_req in reset", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        for (int s = 0; s < 8; s++) begin
            cfg_read(3'(s), rd);
            check($sformatf("R1 word %0d after reset", s), 64'(rd), 64'd0);
        end

        // directed: constant ops with full masks never read the destination
        randomize_cfg();
        c_op = 4'h0; c_m1 = 16'hFFFF; c_m2 = 16'hFFFF; c_m3 = 16'hFFFF;
        c_fx = 0; c_nf = 0; c_x = 4; c_y = 2;
        run_one("op0 full masks", 0);
        c_op = 4'hF;
        run_one("opF full masks", 0);
        c_op = 4'h3;
        run_one("op3 full masks", 0);
        // directed: one-word line with both flags
        randomize_cfg();
        c_x = 1; c_y = 3; c_fx = 1; c_nf = 1;
        run_one("one-word both flags", 0);
        // directed: row wrap down and up
        randomize_cfg();
        c_line = 4'h0; c_dyi = 15'h7FFE; c_y = 3;
        run_one("row wrap down", 0);
        randomize_cfg();
        c_line = 4'hF; c_dyi = 15'h0040; c_y = 2;
        run_one("row wrap up", 0);
        // directed: writes while busy are ignored
        randomize_cfg();
        c_x = 4; c_y = 3; c_nf = 1;
        run_one("writes while busy", 1);
        // random mix
        for (int t = 0; t < 40; t++) begin
            randomize_cfg();
            run_one($sformatf("random %0d", t), 0);
        end
        done = 1;
        finish_run();
    end
endmodule